// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Processor Core

This block is a small processor with an 8-bit datapath. It executes programs held in a 256-byte memory that stores both code and data. Every instruction starts with an opcode byte and carries up to two operand bytes. The core owns eight general registers. The last register also serves as the stack pointer, and the stack grows toward lower addresses. The core also keeps a program counter, a three-bit compare flag field and a halted state.

Each instruction takes two clock cycles. In the first cycle the core latches the opcode and both operand bytes. In the second cycle it performs the operation. A print instruction places a register value on an output port together with a strobe that stays high for one cycle. A testbench or boot agent fills the memory through a load port while it holds the core in reset. An unknown opcode stops the core and raises a sticky error output.

Top module: `byte_cpu_core`

## Requirements
- R1: After reset the program counter is 0, register 7 holds 0xF4, all other registers and the flags hold 0, and `halted`, `error` and `prn_valid` are low.
- R2: The core fetches the opcode from memory at PC and the operands from PC+1 and PC+2, all modulo 256. Each instruction takes two cycles, so a print from the instruction at address 0 strobes in the second cycle after reset is released and a print from the next instruction strobes two cycles later.
- R3: LDI (0x82) writes byte B into register A. PRN (0x47) drives register A on `prn_data` with `prn_valid` high for exactly one cycle. A register is selected by the low three bits of its operand byte. LDI is three bytes long and PRN is two.
- R4: MUL (0xA2) writes the low 8 bits of register A times register B into register A. It is three bytes long.
- R5: PUSH (0x45) first decrements register 7 and then stores register A at the new register 7 address. POP (0x46) loads register A from memory at register 7 and then increments register 7. Both are two bytes long.
- R6: CMP (0xA7) compares register A with register B as unsigned values. It sets the flags to 00000LGE (bit 2 less, bit 1 greater, bit 0 equal) with exactly one bit set. It is three bytes long.
- R7: JMP (0x54) loads PC from register A. JEQ (0x55) does the same only when the equal flag is 1, and JNE (0x56) only when it is 0. A conditional jump that is not taken advances PC by 2.
- R8: CALL (0x50) pushes PC+2 onto the stack and loads PC from register A. RET (0x11) pops the top of the stack into PC.
- R9: HLT (0x01) places the core in the halted state. The core stays there, with no further prints or memory writes, until reset.
- R10: Any opcode outside the twelve listed ones halts the core and sets `error`. `error` stays high until reset.
- R11: The load port writes memory only while `rst_n` is low. Load writes while the core runs or is halted have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables the load port |
| load_en | input | 1 | Memory preload write enable (acts only in reset) |
| load_addr | input | ADDR_W | Memory preload address |
| load_data | input | DATA_W | Memory preload byte |
| prn_valid | output | 1 | One-cycle strobe for a printed value |
| prn_data | output | DATA_W | Value printed by the last PRN |
| halted | output | 1 | Core has stopped |
| error | output | 1 | An unknown opcode stopped the core |

## Verification
The embedded assertions check these properties on every cycle:
- the halted state is sticky;
- an error always comes with a halt;
- the print strobe never lasts two cycles;
- no memory write happens while halted;
- PUSH always lowers the stack register by one;
- every CMP leaves exactly one flag set.

Only the bench's scenarios can show the values themselves:
- multiplication results across a sweep of operand pairs;
- branch outcomes of JEQ and JNE for equal and unequal pairs;
- the LIFO order of pushed and popped data;
- CALL/RET return linkage;
- whether load writes outside reset are dropped;
- that every undefined opcode ends in an error.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;

   localparam logic [7:0] OP_HLT  = 8'h01;
   localparam logic [7:0] OP_LDI  = 8'h82;
   localparam logic [7:0] OP_PRN  = 8'h47;
   localparam logic [7:0] OP_MUL  = 8'hA2;
   localparam logic [7:0] OP_PUSH = 8'h45;
   localparam logic [7:0] OP_POP  = 8'h46;
   localparam logic [7:0] OP_CALL = 8'h50;
   localparam logic [7:0] OP_RET  = 8'h11;
   localparam logic [7:0] OP_CMP  = 8'hA7;
   localparam logic [7:0] OP_JMP  = 8'h54;
   localparam logic [7:0] OP_JEQ  = 8'h55;
   localparam logic [7:0] OP_JNE  = 8'h56;

   localparam int FLG_W = 3;
   localparam int FLG_E = 0;
   localparam int FLG_G = 1;
   localparam int FLG_L = 2;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EXEC  = 2'd1,
      ST_HALT  = 2'd2
   } cpu_state_t;

endpackage

// File: rtl/bcpu_mem.sv
module bcpu_mem #(
   parameter int DW  = 8,
   parameter int AW  = 8,
   parameter int NRD = 4
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0][DW-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("bcpu_mem: AW out of range");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("bcpu_mem: NRD must be at least 1");
   end

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = store[raddr[p]];
   end

endmodule

// File: rtl/bcpu_regfile.sv
module bcpu_regfile #(
   parameter int             DW      = 8,
   parameter int             NREG    = 8,
   parameter int             SP_IDX  = 7,
   parameter logic [DW-1:0]  SP_INIT = 'hF4,
   localparam int            SW      = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [SW-1:0]  wsel,
   input  logic [DW-1:0]  wdata,
   input  logic           sp_we,
   input  logic [DW-1:0]  sp_wdata,
   input  logic [SW-1:0]  rsel_a,
   input  logic [SW-1:0]  rsel_b,
   output logic [DW-1:0]  rdata_a,
   output logic [DW-1:0]  rdata_b,
   output logic [DW-1:0]  sp
);
   if (SP_IDX < 0 || SP_IDX >= NREG) begin : g_bad_sp
      $error("bcpu_regfile: SP_IDX outside register file");
   end

   logic [DW-1:0] rview [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] q;
      if (i == SP_IDX) begin : g_sp
         // general write port wins over the stack update (POP into the SP)
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       q <= SP_INIT;
            else if (we && wsel == SW'(i))    q <= wdata;
            else if (sp_we)                   q <= sp_wdata;
         end
      end else begin : g_gp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       q <= '0;
            else if (we && wsel == SW'(i))    q <= wdata;
         end
      end
      assign rview[i] = q;
   end

   assign rdata_a = rview[rsel_a];
   assign rdata_b = rview[rsel_b];
   assign sp      = rview[SP_IDX];

endmodule

// File: rtl/bcpu_alu.sv
module bcpu_alu
   import bcpu_pkg::*;
#(
   parameter int DW        = 8,
   parameter int MUL_STYLE = 0
) (
   input  logic [DW-1:0]     a,
   input  logic [DW-1:0]     b,
   output logic [DW-1:0]     prod,
   output logic [FLG_W-1:0]  cmp_flags
);
   if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
      $error("bcpu_alu: MUL_STYLE must be 0 or 1");
   end

   if (MUL_STYLE == 0) begin : g_mul_op
      assign prod = a * b;
   end else begin : g_mul_shadd
      logic [DW-1:0] acc;
      always_comb begin
         acc = '0;
         for (int k = 0; k < DW; k++) begin
            if (b[k]) acc = acc + (a << k);
         end
      end
      assign prod = acc;
   end

   assign cmp_flags[FLG_E] = (a == b);
   assign cmp_flags[FLG_G] = (a > b);
   assign cmp_flags[FLG_L] = (a < b);

endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
   import bcpu_pkg::*;
#(
   parameter int             DATA_W    = 8,
   parameter int             ADDR_W    = 8,
   parameter int             NREG      = 8,
   parameter int             SP_IDX    = 7,
   parameter logic [DATA_W-1:0] SP_INIT = 'hF4,
   parameter int             MUL_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [ADDR_W-1:0]  load_addr,
   input  logic [DATA_W-1:0]  load_data,
   output logic               prn_valid,
   output logic [DATA_W-1:0]  prn_data,
   output logic               halted,
   output logic               error
);
   localparam int RSEL_W = $clog2(NREG);
   localparam int NRD    = 4;
   localparam int RD_SP  = 3;

   if (DATA_W < 8) begin : g_bad_dw
      $error("byte_cpu_core: DATA_W must hold an opcode byte");
   end
   if (ADDR_W > DATA_W) begin : g_bad_aw
      $error("byte_cpu_core: ADDR_W must fit in a register");
   end
   if (NREG != (1 << RSEL_W) || NREG < 2) begin : g_bad_nreg
      $error("byte_cpu_core: NREG must be a power of two");
   end

   cpu_state_t           state;
   logic [ADDR_W-1:0]    pc, pc_nx;
   logic [DATA_W-1:0]    ir, opa, opb;
   logic [FLG_W-1:0]     flags, flags_nx, alu_flags;
   logic                 err_q, prn_v_q;
   logic [DATA_W-1:0]    prn_d_q;

   logic [RSEL_W-1:0]    ra, rb;
   logic [DATA_W-1:0]    va, vb, sp, prod;

   logic                 rf_we, sp_we, cw_we, go_halt, bad_op, do_prn;
   logic [DATA_W-1:0]    rf_wdata, sp_wdata, cw_data;
   logic [ADDR_W-1:0]    cw_addr;

   logic [NRD-1:0][ADDR_W-1:0] m_raddr;
   logic [NRD-1:0][DATA_W-1:0] m_rdata;
   logic                 m_we;
   logic [ADDR_W-1:0]    m_waddr;
   logic [DATA_W-1:0]    m_wdata;

   logic                 unused_bits;
   assign unused_bits = ^{opa[DATA_W-1:RSEL_W], flags};

   assign ra = opa[RSEL_W-1:0];
   assign rb = opb[RSEL_W-1:0];

   assign m_raddr[0]     = pc;
   assign m_raddr[1]     = pc + ADDR_W'(1);
   assign m_raddr[2]     = pc + ADDR_W'(2);
   assign m_raddr[RD_SP] = sp[ADDR_W-1:0];

   // preload path only while reset is held
   always_comb begin
      if (!rst_n) begin
         m_we    = load_en;
         m_waddr = load_addr;
         m_wdata = load_data;
      end else begin
         m_we    = cw_we;
         m_waddr = cw_addr;
         m_wdata = cw_data;
      end
   end

   bcpu_mem #(.DW(DATA_W), .AW(ADDR_W), .NRD(NRD)) u_mem (
      .clk   (clk),
      .we    (m_we),
      .waddr (m_waddr),
      .wdata (m_wdata),
      .raddr (m_raddr),
      .rdata (m_rdata)
   );

   bcpu_regfile #(.DW(DATA_W), .NREG(NREG), .SP_IDX(SP_IDX), .SP_INIT(SP_INIT)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (rf_we),
      .wsel     (ra),
      .wdata    (rf_wdata),
      .sp_we    (sp_we),
      .sp_wdata (sp_wdata),
      .rsel_a   (ra),
      .rsel_b   (rb),
      .rdata_a  (va),
      .rdata_b  (vb),
      .sp       (sp)
   );

   bcpu_alu #(.DW(DATA_W), .MUL_STYLE(MUL_STYLE)) u_alu (
      .a         (va),
      .b         (vb),
      .prod      (prod),
      .cmp_flags (alu_flags)
   );

   // execute-stage decode
   always_comb begin
      pc_nx    = pc;
      flags_nx = flags;
      rf_we    = 1'b0;
      rf_wdata = opb;
      sp_we    = 1'b0;
      sp_wdata = sp;
      cw_we    = 1'b0;
      cw_addr  = sp[ADDR_W-1:0] - ADDR_W'(1);
      cw_data  = va;
      go_halt  = 1'b0;
      bad_op   = 1'b0;
      do_prn   = 1'b0;
      if (state == ST_EXEC) begin
         case (ir[7:0])
            OP_HLT: begin
               pc_nx   = pc + ADDR_W'(1);
               go_halt = 1'b1;
            end
            OP_LDI: begin
               rf_we    = 1'b1;
               rf_wdata = opb;
               pc_nx    = pc + ADDR_W'(3);
            end
            OP_PRN: begin
               do_prn = 1'b1;
               pc_nx  = pc + ADDR_W'(2);
            end
            OP_MUL: begin
               rf_we    = 1'b1;
               rf_wdata = prod;
               pc_nx    = pc + ADDR_W'(3);
            end
            OP_PUSH: begin
               sp_we    = 1'b1;
               sp_wdata = sp - DATA_W'(1);
               cw_we    = 1'b1;
               cw_data  = va;
               pc_nx    = pc + ADDR_W'(2);
            end
            OP_POP: begin
               rf_we    = 1'b1;
               rf_wdata = m_rdata[RD_SP];
               sp_we    = 1'b1;
               sp_wdata = sp + DATA_W'(1);
               pc_nx    = pc + ADDR_W'(2);
            end
            OP_CALL: begin
               sp_we    = 1'b1;
               sp_wdata = sp - DATA_W'(1);
               cw_we    = 1'b1;
               cw_data  = DATA_W'(pc + ADDR_W'(2));
               pc_nx    = va[ADDR_W-1:0];
            end
            OP_RET: begin
               sp_we    = 1'b1;
               sp_wdata = sp + DATA_W'(1);
               pc_nx    = m_rdata[RD_SP][ADDR_W-1:0];
            end
            OP_CMP: begin
               flags_nx = alu_flags;
               pc_nx    = pc + ADDR_W'(3);
            end
            OP_JMP: pc_nx = va[ADDR_W-1:0];
            OP_JEQ: pc_nx = flags[FLG_E] ? va[ADDR_W-1:0] : pc + ADDR_W'(2);
            OP_JNE: pc_nx = flags[FLG_E] ? pc + ADDR_W'(2) : va[ADDR_W-1:0];
            default: begin
               go_halt = 1'b1;
               bad_op  = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_FETCH;
         pc      <= '0;
         ir      <= '0;
         opa     <= '0;
         opb     <= '0;
         flags   <= '0;
         err_q   <= 1'b0;
         prn_v_q <= 1'b0;
         prn_d_q <= '0;
      end else begin
         prn_v_q <= 1'b0;
         case (state)
            ST_FETCH: begin
               ir    <= m_rdata[0];
               opa   <= m_rdata[1];
               opb   <= m_rdata[2];
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               pc      <= pc_nx;
               flags   <= flags_nx;
               prn_v_q <= do_prn;
               if (do_prn) prn_d_q <= va;
               if (bad_op) err_q <= 1'b1;
               state   <= go_halt ? ST_HALT : ST_FETCH;
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   assign prn_valid = prn_v_q;
   assign prn_data  = prn_d_q;
   assign halted    = (state == ST_HALT);
   assign error     = err_q;

   // R9
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!m_we && !prn_valid));

   // R10
   err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> halted);

   // R3
   prn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prn_valid |=> !prn_valid);

   // R5
   push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir[7:0] == OP_PUSH) |=> (sp == $past(sp) - DATA_W'(1)));

   // R6
   cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && ir[7:0] == OP_CMP) |=> ($countones(flags) == 1));

endmodule

// File: tb/sim_byte_cpu_core.sv
`timescale 1ns/1ps
module sim_byte_cpu_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic [7:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic       prn_valid;
   logic [7:0] prn_data;
   logic       halted;
   logic       error;

   always #2 clk = ~clk;

   byte_cpu_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data),
      .prn_valid (prn_valid),
      .prn_data  (prn_data),
      .halted    (halted),
      .error     (error)
   );

   int tests = 0;
   int fails = 0;
   logic [7:0] prog [256];
   logic [7:0] pv [16];
   int         pcy [16];
   int         pn;

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int k = 0; k < 256; k++) prog[k] = 8'h00;
   endtask

   task automatic load_prog(input int n);
      rst_n = 1'b0;
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         load_addr = 8'(k);
         load_data = prog[k];
         load_en   = 1'b1;
         @(negedge clk);
      end
      load_en = 1'b0;
   endtask

   task automatic go(input int limit);
      int cyc;
      int extra;
      cyc = 0;
      extra = 0;
      pn = 0;
      rst_n = 1'b1;
      while (extra < 4 && cyc < limit) begin
         @(negedge clk);
         cyc++;
         if (prn_valid) begin
            if (pn < 16) begin
               pv[pn]  = prn_data;
               pcy[pn] = cyc;
            end
            pn++;
         end
         if (halted) extra++;
      end
   endtask

   function automatic bit known_op(input logic [7:0] op);
      case (op)
         8'h01, 8'h82, 8'h47, 8'hA2, 8'h45, 8'h46,
         8'h50, 8'h11, 8'hA7, 8'h54, 8'h55, 8'h56: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] va_l [6];
      va_l[0] = 8'h00; va_l[1] = 8'h01; va_l[2] = 8'h7F;
      va_l[3] = 8'h80; va_l[4] = 8'hFE; va_l[5] = 8'hFF;

      // R1 / R2: reset state and two-cycle timing
      clear_prog();
      prog[0] = 8'h47; prog[1] = 8'h07;
      prog[2] = 8'h47; prog[3] = 8'h00;
      prog[4] = 8'h47; prog[5] = 8'h03;
      prog[6] = 8'h01;
      load_prog(7);
      check("R1 halted in reset", int'(halted), 0);
      check("R1 error in reset", int'(error), 0);
      check("R1 prn_valid in reset", int'(prn_valid), 0);
      go(100);
      check("R1 print count", pn, 3);
      check("R1 R7 reset value", int'(pv[0]), 'hF4);
      check("R1 R0 reset value", int'(pv[1]), 0);
      check("R1 R3 reset value", int'(pv[2]), 0);
      check("R2 first print cycle", pcy[0], 2);
      check("R2 second print cycle", pcy[1], 4);
      check("R9 halted after HLT", int'(halted), 1);

      // R3: register select by low three bits
      clear_prog();
      prog[0] = 8'h82; prog[1] = 8'h0D; prog[2] = 8'h77;
      prog[3] = 8'h47; prog[4] = 8'h05;
      prog[5] = 8'h01;
      load_prog(6);
      go(100);
      check("R3 print count", pn, 1);
      check("R3 LDI/PRN value", int'(pv[0]), 'h77);

      // R4: multiply sweep
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            int a;
            int b;
            a = i * 17;
            b = (j * 29 + 3) & 255;
            clear_prog();
            prog[0] = 8'h82; prog[1] = 8'h01; prog[2] = 8'(a);
            prog[3] = 8'h82; prog[4] = 8'h02; prog[5] = 8'(b);
            prog[6] = 8'hA2; prog[7] = 8'h01; prog[8] = 8'h02;
            prog[9] = 8'h47; prog[10] = 8'h01;
            prog[11] = 8'h01;
            load_prog(12);
            go(100);
            check("R4 MUL product", (pn == 1) ? int'(pv[0]) : -1, (a * b) & 255);
         end
      end

      // R6 / R7: compare sweep with JEQ and JNE
      for (int jt = 0; jt < 2; jt++) begin
         for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
               bit take;
               clear_prog();
               prog[0]  = 8'h82; prog[1]  = 8'h01; prog[2]  = va_l[i];
               prog[3]  = 8'h82; prog[4]  = 8'h02; prog[5]  = va_l[j];
               prog[6]  = 8'h82; prog[7]  = 8'h03; prog[8]  = 8'd20;
               prog[9]  = 8'hA7; prog[10] = 8'h01; prog[11] = 8'h02;
               prog[12] = (jt == 0) ? 8'h55 : 8'h56; prog[13] = 8'h03;
               prog[14] = 8'h82; prog[15] = 8'h04; prog[16] = 8'h11;
               prog[17] = 8'h47; prog[18] = 8'h04;
               prog[19] = 8'h01;
               prog[20] = 8'h82; prog[21] = 8'h04; prog[22] = 8'hEE;
               prog[23] = 8'h47; prog[24] = 8'h04;
               prog[25] = 8'h01;
               load_prog(26);
               go(100);
               take = (jt == 0) ? (va_l[i] == va_l[j]) : (va_l[i] != va_l[j]);
               check(jt == 0 ? "R6 R7 JEQ after CMP" : "R6 R7 JNE after CMP",
                     (pn == 1) ? int'(pv[0]) : -1, take ? 'hEE : 'h11);
            end
         end
      end

      // R7: unconditional jump
      clear_prog();
      prog[0] = 8'h82; prog[1] = 8'h03; prog[2] = 8'h08;
      prog[3] = 8'h54; prog[4] = 8'h03;
      prog[5] = 8'h47; prog[6] = 8'h07;
      prog[7] = 8'h01;
      prog[8] = 8'h82; prog[9] = 8'h00; prog[10] = 8'h42;
      prog[11] = 8'h47; prog[12] = 8'h00;
      prog[13] = 8'h01;
      load_prog(14);
      go(100);
      check("R7 JMP print count", pn, 1);
      check("R7 JMP target value", int'(pv[0]), 'h42);

      // R5: push/pop order and stack register
      clear_prog();
      prog[0]  = 8'h82; prog[1]  = 8'h01; prog[2]  = 8'h3C;
      prog[3]  = 8'h82; prog[4]  = 8'h02; prog[5]  = 8'h5A;
      prog[6]  = 8'h45; prog[7]  = 8'h01;
      prog[8]  = 8'h45; prog[9]  = 8'h02;
      prog[10] = 8'h47; prog[11] = 8'h07;
      prog[12] = 8'h46; prog[13] = 8'h04;
      prog[14] = 8'h46; prog[15] = 8'h05;
      prog[16] = 8'h47; prog[17] = 8'h04;
      prog[18] = 8'h47; prog[19] = 8'h05;
      prog[20] = 8'h47; prog[21] = 8'h07;
      prog[22] = 8'h01;
      load_prog(23);
      go(200);
      check("R5 print count", pn, 4);
      check("R5 SP after two pushes", int'(pv[0]), 'hF2);
      check("R5 first pop", int'(pv[1]), 'h5A);
      check("R5 second pop", int'(pv[2]), 'h3C);
      check("R5 SP restored", int'(pv[3]), 'hF4);

      // R8: call and return
      clear_prog();
      prog[0]  = 8'h82; prog[1]  = 8'h01; prog[2]  = 8'h10;
      prog[3]  = 8'h50; prog[4]  = 8'h01;
      prog[5]  = 8'h47; prog[6]  = 8'h02;
      prog[7]  = 8'h47; prog[8]  = 8'h07;
      prog[9]  = 8'h01;
      prog[16] = 8'h82; prog[17] = 8'h02; prog[18] = 8'h66;
      prog[19] = 8'h47; prog[20] = 8'h07;
      prog[21] = 8'h11;
      load_prog(22);
      go(200);
      check("R8 print count", pn, 3);
      check("R8 SP inside call", int'(pv[0]), 'hF3);
      check("R8 value after return", int'(pv[1]), 'h66);
      check("R8 SP after return", int'(pv[2]), 'hF4);

      // R9: halt stops execution
      clear_prog();
      prog[0] = 8'h01;
      prog[1] = 8'h47; prog[2] = 8'h07;
      load_prog(3);
      go(100);
      repeat (20) @(negedge clk);
      check("R9 no print after HLT", pn, 0);
      check("R9 halted stays", int'(halted), 1);
      check("R9 no error on HLT", int'(error), 0);

      // R10: unknown opcode
      clear_prog();
      prog[0] = 8'h47; prog[1] = 8'h07;
      prog[2] = 8'hFF;
      prog[3] = 8'h47; prog[4] = 8'h07;
      load_prog(5);
      go(100);
      check("R10 print before bad op", pn, 1);
      check("R10 error raised", int'(error), 1);
      check("R10 halted", int'(halted), 1);
      for (int op = 0; op < 256; op++) begin
         if (!known_op(8'(op))) begin
            prog[0] = 8'(op); prog[1] = 8'h00; prog[2] = 8'h00;
            prog[3] = 8'h47;  prog[4] = 8'h07;
            load_prog(5);
            go(50);
            check("R10 undefined opcode error", int'(error & halted) + 2 * pn, 1);
         end
      end

      // R11: load port ignored outside reset
      clear_prog();
      prog[0] = 8'h82; prog[1] = 8'h00; prog[2] = 8'h05;
      prog[3] = 8'h47; prog[4] = 8'h00;
      prog[5] = 8'h01;
      load_prog(6);
      go(100);
      check("R11 baseline value", int'(pv[0]), 'h05);
      load_addr = 8'h02;
      load_data = 8'h99;
      load_en   = 1'b1;
      repeat (3) @(negedge clk);
      load_en   = 1'b0;
      load_prog(0);
      @(negedge clk);
      go(100);
      check("R11 memory unchanged by late load", (pn == 1) ? int'(pv[0]) : -1, 'h05);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule